// File: doc/BRIEF.md
# Fault Isolation Register Bank with Attention Routing

This block collects hardware error indications into a bank of sticky fault bits and sorts every active bit into one of four attention classes. A one-cycle pulse on an error input sets the matching fault bit. The bit stays set until software clears it. Each bit has a mask bit that silences it. Each bit also has a two-bit action code, built from one bit of each action register. The code picks the class that the bit reports to: checkstop, recoverable, host attention or unit checkstop. Each class has its own registered summary line, the OR of all bits routed to that class.

Software reaches the bank over a simple register bus with an enable, a write strobe, a 3-bit offset and 64-bit data. Besides direct writes, the bus has two alias offsets. One clears fault bits by AND with the written data. The other sets mask bits by OR with the written data. These let firmware change selected bits without a read-modify-write. Read data and the access-error flag are registered and are valid one clock after the access.

Top module: `fault_attn_bank`

## Requirements
- R1: After reset all fault bits are 0, all mask bits are 1, both action registers are 0, all four attention outputs are low and `bus_err` is low.
- R2: A 1 on `err_in[i]` at a clock edge sets fault bit i. The bit stays set with no further input until software clears it at offset 0 or offset 1.
- R3: If an error input sets a bit in the same cycle that a bus write at offset 0 or 1 clears it, the bit ends up set.
- R4: A write at offset 0 replaces the fault register with the write data. A read at offset 0 returns the fault register.
- R5: A write at offset 1 clears every fault bit whose data bit is 0 and leaves the other fault bits unchanged. A read at offset 1 returns the fault register.
- R6: A write at offset 3 replaces the mask. A write at offset 5 sets every mask bit whose data bit is 1 and keeps the other mask bits. Reads at offsets 3 and 5 return the mask.
- R7: Offsets 6 and 7 read and write action register 0 and action register 1. The two registers change only on writes to their own offset.
- R8: A bit that is set and unmasked raises exactly one class, chosen by (action0, action1): 00 raises `attn_xstop`, 01 raises `attn_recov`, 10 raises `attn_host`, 11 raises `attn_unitstop`.
- R9: A set mask bit keeps its fault bit out of all four attention outputs. The fault bit still latches and reads back as 1.
- R10: Each attention output is registered. It reflects the fault, mask and action state of the previous clock, so an error pulse sampled at edge k shows at the output after edge k+1.
- R11: Offsets 2 and 4 are unmapped. Reads there return 0, writes there change no register, and either access makes `bus_err` high for the one cycle after the access.
- R12: `bus_rdata` and `bus_err` are registered. They take the value of the access that was sampled at the previous clock edge. `bus_err` is low after any cycle without an unmapped access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_in | input | 64 | Per-bit error pulses that set fault bits |
| bus_en | input | 1 | Bus access strobe for one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset within the bank |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, valid the cycle after the access |
| bus_err | output | 1 | Unmapped-offset flag, valid the cycle after the access |
| attn_xstop | output | 1 | Checkstop class summary |
| attn_recov | output | 1 | Recoverable class summary |
| attn_host | output | 1 | Host-attention class summary |
| attn_unitstop | output | 1 | Unit-checkstop class summary |

## Verification
The hardest case to reach from the ports is a set and a clear landing on the same fault bit in the same cycle. The bench reaches it by holding an error pulse and an AND-alias write of zero in one cycle, then reading the bit back. Every class route needs a specific combination of mask and action values on one chosen bit. A vector table covers these: for each entry the bench programs the mask and action registers, clears the bank, pulses only that bit, and compares all four attention lines together. Masked entries also read the fault register back, to show that the bit latched even though no attention line rose.

// File: rtl/fab_pkg.sv
// Package: shared offsets, class codes and decoded-strobe type for the
// fault attention bank. Assumes a 3-bit offset space with eight slots.
package fab_pkg;

    localparam int unsigned OFF_W   = 3;
    localparam int unsigned NUM_CLS = 4;

    localparam logic [OFF_W-1:0] OFS_FAULT     = 3'd0;
    localparam logic [OFF_W-1:0] OFS_FAULT_AND = 3'd1;
    localparam logic [OFF_W-1:0] OFS_HOLE_A    = 3'd2;
    localparam logic [OFF_W-1:0] OFS_MASK      = 3'd3;
    localparam logic [OFF_W-1:0] OFS_HOLE_B    = 3'd4;
    localparam logic [OFF_W-1:0] OFS_MASK_OR   = 3'd5;
    localparam logic [OFF_W-1:0] OFS_ACT0      = 3'd6;
    localparam logic [OFF_W-1:0] OFS_ACT1      = 3'd7;

    // Class index equals the {action0, action1} code of a bit.
    typedef enum logic [1:0] {
        CLS_XSTOP = 2'b00,
        CLS_RECOV = 2'b01,
        CLS_HOST  = 2'b10,
        CLS_UNIT  = 2'b11
    } attn_cls_e;

    // One-hot-or-zero write strobes produced by the decoder.
    typedef struct packed {
        logic fault_wr;
        logic fault_and;
        logic mask_wr;
        logic mask_or;
        logic act0_wr;
        logic act1_wr;
    } wr_sel_t;

endpackage

// File: rtl/fab_bus_decode.sv
// Module: decodes a bus offset into write strobes and returns registered
// read data and a registered unmapped-offset flag.
// Assumes single-cycle accesses; read data shows the state before any
// write sampled in the same cycle.
module fab_bus_decode #(
    parameter int unsigned W = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_en,
    input  logic                      bus_we,
    input  logic [fab_pkg::OFF_W-1:0] bus_addr,
    input  logic [W-1:0]              fault_q,
    input  logic [W-1:0]              mask_q,
    input  logic [W-1:0]              act0_q,
    input  logic [W-1:0]              act1_q,
    output fab_pkg::wr_sel_t          wr_sel,
    output logic [W-1:0]              rdata_q,
    output logic                      err_q
);
    import fab_pkg::*;

    logic         wr_go;
    logic         hole;
    logic [W-1:0] rd_mux;

    // Purpose: turn a write access into one strobe per target register.
    always_comb begin
        wr_go            = bus_en && bus_we;
        wr_sel           = '0;
        wr_sel.fault_wr  = wr_go && (bus_addr == OFS_FAULT);
        wr_sel.fault_and = wr_go && (bus_addr == OFS_FAULT_AND);
        wr_sel.mask_wr   = wr_go && (bus_addr == OFS_MASK);
        wr_sel.mask_or   = wr_go && (bus_addr == OFS_MASK_OR);
        wr_sel.act0_wr   = wr_go && (bus_addr == OFS_ACT0);
        wr_sel.act1_wr   = wr_go && (bus_addr == OFS_ACT1);
    end

    // Purpose: select read data by offset and flag the unmapped holes.
    always_comb begin
        hole   = 1'b0;
        rd_mux = '0;
        unique case (bus_addr)
            OFS_FAULT, OFS_FAULT_AND: rd_mux = fault_q;
            OFS_MASK,  OFS_MASK_OR:   rd_mux = mask_q;
            OFS_ACT0:                 rd_mux = act0_q;
            OFS_ACT1:                 rd_mux = act1_q;
            OFS_HOLE_A, OFS_HOLE_B:   hole   = 1'b1;
            default:                  hole   = 1'b1;
        endcase
    end

    // Purpose: register read data and the error flag for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= bus_en && hole;
            if (bus_en && !bus_we) begin
                rdata_q <= rd_mux;
            end else begin
                rdata_q <= '0;
            end
        end
    end

endmodule

// File: rtl/fab_regfile.sv
// Module: holds the sticky fault bits, the mask and the two action
// registers. Error inputs take priority over any clear in the same cycle.
// Assumes the strobes from the decoder are mutually exclusive.
module fab_regfile #(
    parameter int unsigned W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fab_pkg::wr_sel_t wr_sel,
    input  logic [W-1:0]     wdata,
    input  logic [W-1:0]     err_in,
    output logic [W-1:0]     fault_q,
    output logic [W-1:0]     mask_q,
    output logic [W-1:0]     act0_q,
    output logic [W-1:0]     act1_q
);

    logic [W-1:0] fault_base;
    logic [W-1:0] mask_nxt;

    // Purpose: apply any software write to the fault bits, before error sets.
    always_comb begin
        if (wr_sel.fault_wr) begin
            fault_base = wdata;
        end else if (wr_sel.fault_and) begin
            fault_base = fault_q & wdata;
        end else begin
            fault_base = fault_q;
        end
    end

    // Purpose: compute the next mask from a direct or OR-set write.
    always_comb begin
        if (wr_sel.mask_wr) begin
            mask_nxt = wdata;
        end else if (wr_sel.mask_or) begin
            mask_nxt = mask_q | wdata;
        end else begin
            mask_nxt = mask_q;
        end
    end

    // Purpose: latch fault bits; an error pulse wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= '0;
        end else begin
            fault_q <= fault_base | err_in;
        end
    end

    // Purpose: hold the mask, all bits masked out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else begin
            mask_q <= mask_nxt;
        end
    end

    // Purpose: hold the two action registers written only directly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act0_q <= '0;
            act1_q <= '0;
        end else begin
            if (wr_sel.act0_wr) begin
                act0_q <= wdata;
            end
            if (wr_sel.act1_wr) begin
                act1_q <= wdata;
            end
        end
    end

endmodule

// File: rtl/fab_classify.sv
// Module: routes every unmasked set fault bit to the class named by its
// action code and registers one OR summary per class.
// Assumes class index bit 1 matches action0 and bit 0 matches action1.
module fab_classify #(
    parameter int unsigned W = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [W-1:0]                fault_q,
    input  logic [W-1:0]                mask_q,
    input  logic [W-1:0]                act0_q,
    input  logic [W-1:0]                act1_q,
    output logic [fab_pkg::NUM_CLS-1:0] attn_q
);
    import fab_pkg::*;

    logic [W-1:0] live;

    // Purpose: keep only bits that are set and not masked.
    always_comb begin
        live = fault_q & ~mask_q;
    end

    for (genvar c = 0; c < int'(NUM_CLS); c++) begin : g_cls
        localparam logic WANT0 = c[1];
        localparam logic WANT1 = c[0];
        logic [W-1:0] sel0;
        logic [W-1:0] sel1;
        logic [W-1:0] hits;

        // Purpose: pick the bits whose action code matches this class.
        always_comb begin
            sel0 = WANT0 ? act0_q : ~act0_q;
            sel1 = WANT1 ? act1_q : ~act1_q;
            hits = live & sel0 & sel1;
        end

        // Purpose: register the OR summary of this class.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                attn_q[c] <= 1'b0;
            end else begin
                attn_q[c] <= |hits;
            end
        end
    end

endmodule

// File: rtl/fault_attn_bank.sv
// Module: top of the fault bank. It ties the bus decoder, the register
// storage and the class router together and names the four attention lines.
// Assumes a synchronous active-low reset and single-cycle bus accesses.
module fault_attn_bank #(
    parameter int unsigned W = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [W-1:0]              err_in,
    input  logic                      bus_en,
    input  logic                      bus_we,
    input  logic [fab_pkg::OFF_W-1:0] bus_addr,
    input  logic [W-1:0]              bus_wdata,
    output logic [W-1:0]              bus_rdata,
    output logic                      bus_err,
    output logic                      attn_xstop,
    output logic                      attn_recov,
    output logic                      attn_host,
    output logic                      attn_unitstop
);
    import fab_pkg::*;

    wr_sel_t              wr_sel;
    logic [W-1:0]         fault_q;
    logic [W-1:0]         mask_q;
    logic [W-1:0]         act0_q;
    logic [W-1:0]         act1_q;
    logic [NUM_CLS-1:0]   attn_q;

    fab_bus_decode #(.W(W)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_en   (bus_en),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .fault_q  (fault_q),
        .mask_q   (mask_q),
        .act0_q   (act0_q),
        .act1_q   (act1_q),
        .wr_sel   (wr_sel),
        .rdata_q  (bus_rdata),
        .err_q    (bus_err)
    );

    fab_regfile #(.W(W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sel  (wr_sel),
        .wdata   (bus_wdata),
        .err_in  (err_in),
        .fault_q (fault_q),
        .mask_q  (mask_q),
        .act0_q  (act0_q),
        .act1_q  (act1_q)
    );

    fab_classify #(.W(W)) u_cls (
        .clk     (clk),
        .rst_n   (rst_n),
        .fault_q (fault_q),
        .mask_q  (mask_q),
        .act0_q  (act0_q),
        .act1_q  (act1_q),
        .attn_q  (attn_q)
    );

    // Purpose: give each class summary its own named output.
    always_comb begin
        attn_xstop    = attn_q[CLS_XSTOP];
        attn_recov    = attn_q[CLS_RECOV];
        attn_host     = attn_q[CLS_HOST];
        attn_unitstop = attn_q[CLS_UNIT];
    end

endmodule

// File: rtl/fab_checker.sv
// Module: property checker bound to the fault bank top. It observes the
// ports and the register outputs only; it drives nothing.
module fab_checker #(
    parameter int unsigned W = 64
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] err_in,
    input logic         bus_en,
    input logic         bus_we,
    input logic [2:0]   bus_addr,
    input logic         bus_err,
    input logic [W-1:0] fault_q,
    input logic [W-1:0] mask_q,
    input logic [W-1:0] act0_q,
    input logic [W-1:0] act1_q,
    input logic         attn_xstop,
    input logic         attn_recov,
    input logic         attn_host,
    input logic         attn_unitstop
);

    logic attn_any;
    logic fault_wr_acc;
    logic [3:0] attn_vec;

    // Purpose: collect the summary lines and the fault-write access.
    always_comb begin
        attn_vec     = {attn_xstop, attn_recov, attn_host, attn_unitstop};
        attn_any     = |attn_vec;
        fault_wr_acc = bus_en && bus_we && (bus_addr == 3'd0 || bus_addr == 3'd1);
    end

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (fault_q == '0 && mask_q == '1 && act0_q == '0 && act1_q == '0 && !attn_any)); // R1

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_wr_acc |=> ((fault_q & $past(fault_q)) == $past(fault_q))); // R2

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_in) |=> ((fault_q & $past(err_in)) == $past(err_in))); // R3

    AST_ACT0_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_en && bus_we && bus_addr == 3'd6) |=> $stable(act0_q)); // R7

    AST_MASK_SILENCE: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '1) |=> !attn_any); // R9

    AST_ATTN_REGISTERED: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(fault_q) && $stable(mask_q) && $stable(act0_q) && $stable(act1_q)) |=> $stable(attn_vec)); // R10

    AST_HOLE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && (bus_addr == 3'd2 || bus_addr == 3'd4)) |=> bus_err); // R11

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |=> !bus_err); // R12

endmodule

bind fault_attn_bank fab_checker #(.W(W)) u_fab_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .err_in        (err_in),
    .bus_en        (bus_en),
    .bus_we        (bus_we),
    .bus_addr      (bus_addr),
    .bus_err       (bus_err),
    .fault_q       (fault_q),
    .mask_q        (mask_q),
    .act0_q        (act0_q),
    .act1_q        (act1_q),
    .attn_xstop    (attn_xstop),
    .attn_recov    (attn_recov),
    .attn_host     (attn_host),
    .attn_unitstop (attn_unitstop)
);

// File: tb/fault_attn_bank_bench.sv
// Bench: a vector table over class routing and masking, then directed
// tests for reset, bus aliases, unmapped offsets and set-versus-clear.
module fault_attn_bank_bench;

    localparam int unsigned W = 64;

    typedef struct packed {
        logic [5:0] idx;
        logic       a0;
        logic       a1;
        logic       msk;
        logic [3:0] exp;   // {xstop, recov, host, unitstop}
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{6'd0,  1'b0, 1'b0, 1'b0, 4'b1000},
        '{6'd5,  1'b0, 1'b1, 1'b0, 4'b0100},
        '{6'd17, 1'b1, 1'b0, 1'b0, 4'b0010},
        '{6'd63, 1'b1, 1'b1, 1'b0, 4'b0001},
        '{6'd40, 1'b0, 1'b0, 1'b1, 4'b0000},
        '{6'd33, 1'b1, 1'b1, 1'b1, 4'b0000},
        '{6'd12, 1'b0, 1'b1, 1'b0, 4'b0100},
        '{6'd50, 1'b1, 1'b0, 1'b1, 4'b0000}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] err_in = '0;
    logic         bus_en = 1'b0;
    logic         bus_we = 1'b0;
    logic [2:0]   bus_addr = '0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic         bus_err;
    logic         attn_xstop, attn_recov, attn_host, attn_unitstop;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    fault_attn_bank #(.W(W)) u_fault_attn_bank (
        .clk           (clk),
        .rst_n         (rst_n),
        .err_in        (err_in),
        .bus_en        (bus_en),
        .bus_we        (bus_we),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .bus_err       (bus_err),
        .attn_xstop    (attn_xstop),
        .attn_recov    (attn_recov),
        .attn_host     (attn_host),
        .attn_unitstop (attn_unitstop)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [W-1:0] d, output logic e);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata; e = bus_err;
        bus_en = 1'b0;
    endtask

    task automatic pulse(input logic [W-1:0] v);
        @(negedge clk);
        err_in = v;
        @(negedge clk);
        err_in = '0;
    endtask

    function automatic logic [3:0] attn();
        return {attn_xstop, attn_recov, attn_host, attn_unitstop};
    endfunction

    initial begin : main
        logic [W-1:0] d;
        logic         e;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        chk("R1 attn", {60'd0, attn()}, '0);
        chk("R1 bus_err", {63'd0, bus_err}, '0);
        rd(3'd0, d, e); chk("R1 fault", d, '0);
        rd(3'd3, d, e); chk("R1 mask", d, '1);
        rd(3'd6, d, e); chk("R1 act0", d, '0);
        rd(3'd7, d, e); chk("R1 act1", d, '0);

        // Vector table: class routing and masking
        for (int i = 0; i < NV; i++) begin
            logic [W-1:0] bit_v;
            bit_v = 64'd1 << VECS[i].idx;
            wr(3'd3, VECS[i].msk ? '1 : ~bit_v);
            wr(3'd6, VECS[i].a0 ? bit_v : '0);
            wr(3'd7, VECS[i].a1 ? bit_v : '0);
            wr(3'd0, '0);
            @(negedge clk);
            pulse(bit_v);
            chk("R10 attn before", {60'd0, attn()}, '0);
            @(negedge clk);
            chk("R8 class route", {60'd0, attn()}, {60'd0, VECS[i].exp});
            rd(3'd0, d, e);
            chk("R9 fault latched", d, bit_v);
        end

        // Sticky bits and AND-clear alias
        wr(3'd3, '0);
        wr(3'd6, '0);
        wr(3'd7, '0);
        wr(3'd0, '0);
        pulse(64'h8000_0000_0000_0101);
        repeat (4) @(negedge clk);
        rd(3'd0, d, e); chk("R2 sticky", d, 64'h8000_0000_0000_0101);
        chk("R2 attn held", {60'd0, attn()}, 64'd8);
        wr(3'd1, ~64'h1);
        rd(3'd1, d, e); chk("R5 and-clear", d, 64'h8000_0000_0000_0100);

        // Direct fault write
        wr(3'd0, 64'h0123_4567_89AB_CDEF);
        rd(3'd0, d, e); chk("R4 direct write", d, 64'h0123_4567_89AB_CDEF);

        // Set and clear in the same cycle
        wr(3'd0, '0);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = 3'd1; bus_wdata = '0;
        err_in = 64'h0000_0010_0000_0000;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; err_in = '0;
        rd(3'd0, d, e); chk("R3 set wins", d, 64'h0000_0010_0000_0000);

        // Mask direct and OR alias
        wr(3'd3, 64'h00FF);
        wr(3'd5, 64'hF000);
        rd(3'd5, d, e); chk("R6 or-set", d, 64'hF0FF);
        rd(3'd3, d, e); chk("R6 mask read", d, 64'hF0FF);

        // Action registers
        wr(3'd6, 64'hA5A5);
        wr(3'd7, 64'h5A5A);
        rd(3'd6, d, e); chk("R7 act0", d, 64'hA5A5);
        rd(3'd7, d, e); chk("R7 act1", d, 64'h5A5A);

        // Unmapped offsets
        rd(3'd2, d, e);
        chk("R11 hole read data", d, '0);
        chk("R11 hole read err", {63'd0, e}, 64'd1);
        wr(3'd4, '1);
        chk("R11 hole write err", {63'd0, bus_err}, 64'd1);
        rd(3'd3, d, e);
        chk("R11 mask untouched", d, 64'hF0FF);
        chk("R12 err low on mapped read", {63'd0, e}, '0);
        rd(3'd6, d, e); chk("R11 act0 untouched", d, 64'hA5A5);
        rd(3'd0, d, e); chk("R11 fault untouched", d, 64'h0000_0010_0000_0000);
        @(negedge clk);
        chk("R12 err idle", {63'd0, bus_err}, '0);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule